// File: doc/BRIEF.md
# Scan Chain Link

This block is one link of a daisy-chained serial path that stands in front of a small user design. Each link adds eight bits to the path. Serial data enters from the previous link, passes through an 8-bit shift register and leaves towards the next link. The scan clock is forwarded alongside the data, so the following link needs no clock of its own.

Three operations are kept apart. The first is shifting, when the select input is low. The second is a parallel capture of the user design's eight outputs, when the select input is high. The third is a latch step that copies the shift register into a holding register, which drives the design's eight inputs. The design inputs therefore stay steady while data ripples through a long chain, and they change only when the latch step is requested.

All state is clocked on the rising scan clock edge, and reset is synchronous and active low. The latch enable acts as a synchronous enable: it is sampled at a scan clock edge, and that edge copies the shift register contents that were present before it.

Top module: `scan_link`

## Requirements
- R1: While rst_n is low at a rising scan_clk edge, both design_in and the shift register (observed on sdo) become zero.
- R2: With scan_sel low, each rising scan_clk edge moves every bit one place towards sdo and takes sdi into the entry bit, so sdo shows the bit that entered 8 edges earlier.
- R3: With scan_sel high, a rising scan_clk edge loads design_out into the shift register in parallel, and the following shifts present design_out[7] on sdo first and design_out[0] last.
- R4: With latch_en high at a rising scan_clk edge, design_in takes the shift register contents from before that edge.
- R5: While latch_en is low, design_in holds its value through any shifting or capture.
- R6: Of eight bits shifted in and then latched, the first drives design_in[7] and the last drives design_in[0].
- R7: scan_clk_fwd follows scan_clk without a register stage, in both clock phases.
- R8: Two links in cascade, with sdo of the first feeding sdi of the second, form a 16-bit path: the first 8 of 16 shifted bits end up in the second link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock from the previous link or the driver |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_sel | input | 1 | Low: shift serial data; high: capture design outputs |
| latch_en | input | 1 | Copy the shift register to design_in at the next edge |
| sdi | input | 1 | Serial data from the previous link |
| design_out | input | 8 | Outputs of the attached user design |
| design_in | output | 8 | Latched inputs for the attached user design |
| sdo | output | 1 | Serial data to the next link (shift register MSB) |
| scan_clk_fwd | output | 1 | Scan clock passed on to the next link |

## Verification
Every cycle, the assertions check the per-edge register rules: the one-place shift and the entry of sdi, the parallel load during capture, the copy on latch_en, the steadiness of design_in without latch_en, and the clearing on reset. The bench's scenarios are needed for the properties that span many edges. These are the bit order from the first shifted bit to design_in[7], the order in which captured outputs leave on sdo, the 16-bit behaviour of two cascaded links with inverter stubs, and the forwarding of the scan clock in both phases.

// File: rtl/scan_pkg.sv
// Package: scan_pkg
// Shared width and mode encoding for the scan chain link.
// Assumes every link serves a design with equal input and output width.
package scan_pkg;
    localparam int unsigned CELL_W = 8;

    typedef enum logic {
        MODE_SHIFT   = 1'b0,
        MODE_CAPTURE = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/scan_shift_reg.sv
// Module: scan_shift_reg
// Serial shift register with a parallel-load path. In shift mode each bit
// takes its lower neighbour and bit 0 takes sdi. In capture mode all bits
// load from par_in. The MSB is the serial output.
// Assumes a single scan clock domain and a synchronous active-low reset.
module scan_shift_reg #(
    parameter int unsigned WIDTH = scan_pkg::CELL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             sdi,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             sdo
);
    import scan_pkg::*;

    scan_mode_e       mode;
    logic [WIDTH-1:0] nxt;

    // Decode the select pin into the mode encoding.
    assign mode = scan_mode_e'(sel);

    // Per-bit next-state multiplexer: neighbour or sdi when shifting, par_in when capturing.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_head
            assign nxt[i] = (mode == MODE_CAPTURE) ? par_in[i] : sdi;
        end else begin : g_body
            assign nxt[i] = (mode == MODE_CAPTURE) ? par_in[i] : q[i-1];
        end
    end

    // Register the next state, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // Serial output is the bit furthest along the path.
    assign sdo = q[WIDTH-1];

    // R1
    shift_reset_chk: assert property (@(posedge clk) !rst_n |=> q == '0);
    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !sel |=> (q[0] == $past(sdi)) && (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));
    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && sel |=> q == $past(par_in));
endmodule

// File: rtl/scan_hold_reg.sv
// Module: scan_hold_reg
// Holding register that drives the user design's inputs. It copies d when
// load is high at a clock edge and otherwise keeps its value.
// Assumes load is synchronous to clk; reset clears it to zero.
module scan_hold_reg #(
    parameter int unsigned WIDTH = scan_pkg::CELL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Update on load, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R1
    hold_reset_chk: assert property (@(posedge clk) !rst_n |=> q == '0);
    // R4
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && load |=> q == $past(d));
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !load |=> $stable(q));
endmodule

// File: rtl/scan_clk_buf.sv
// Module: scan_clk_buf
// Passes the scan clock on to the next link with no register stage.
// Assumes the physical buffer choice is made during implementation.
module scan_clk_buf (
    input  logic clk_in,
    output logic clk_out
);
    // Forward the clock unchanged.
    assign clk_out = clk_in;
endmodule

// File: rtl/scan_link.sv
// Module: scan_link
// One link of a daisy-chained scan path in front of a small user design.
// It shifts serial data, captures the design outputs and latches design inputs,
// and it forwards data and the scan clock to the next link.
// Assumes all control inputs are synchronous to scan_clk.
module scan_link #(
    parameter int unsigned WIDTH = scan_pkg::CELL_W
) (
    input  logic             scan_clk,
    input  logic             rst_n,
    input  logic             scan_sel,
    input  logic             latch_en,
    input  logic             sdi,
    input  logic [WIDTH-1:0] design_out,
    output logic [WIDTH-1:0] design_in,
    output logic             sdo,
    output logic             scan_clk_fwd
);
    logic [WIDTH-1:0] chain_q;

    // Shift and capture path.
    scan_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk    (scan_clk),
        .rst_n  (rst_n),
        .sel    (scan_sel),
        .sdi    (sdi),
        .par_in (design_out),
        .q      (chain_q),
        .sdo    (sdo)
    );

    // Latched design inputs.
    scan_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk   (scan_clk),
        .rst_n (rst_n),
        .load  (latch_en),
        .d     (chain_q),
        .q     (design_in)
    );

    // Clock forwarding to the next link.
    scan_clk_buf u_clkbuf (
        .clk_in  (scan_clk),
        .clk_out (scan_clk_fwd)
    );
endmodule

// File: tb/test_scan_link.sv
module test_scan_link;
    localparam int PERIOD = 10;
    // Each entry: {pattern shifted in, outputs expected back from the inverter stub}
    localparam logic [15:0] VEC [6] = '{
        16'hA5_5A, 16'h01_FE, 16'h80_7F, 16'hFF_00, 16'h3C_C3, 16'h96_69
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, sel = 1'b0, le = 1'b0, sdi = 1'b0;
    logic [7:0] din_a, dout_a, din_b, dout_b;
    logic       sdo_a, sdo_b, fwd_a, fwd_b;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #(PERIOD/2) clk = ~clk;

    // Inverter stubs stand in for the user designs.
    assign dout_a = ~din_a;
    assign dout_b = ~din_b;

    scan_link i_scan_link (
        .scan_clk(clk), .rst_n(rst_n), .scan_sel(sel), .latch_en(le), .sdi(sdi),
        .design_out(dout_a), .design_in(din_a), .sdo(sdo_a), .scan_clk_fwd(fwd_a)
    );
    scan_link i_scan_link_b (
        .scan_clk(clk), .rst_n(rst_n), .scan_sel(sel), .latch_en(le), .sdi(sdo_a),
        .design_out(dout_b), .design_in(din_b), .sdo(sdo_b), .scan_clk_fwd(fwd_b)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs after a falling edge, then wait past the next rising edge.
    task automatic tick(input logic r, input logic s, input logic l, input logic d);
        @(negedge clk);
        rst_n = r; sel = s; le = l; sdi = d;
        @(posedge clk);
        #(PERIOD/4);
    endtask

    task automatic shift8(input logic [7:0] p);
        for (int i = 7; i >= 0; i--) tick(1, 0, 0, p[i]);
    endtask

    task automatic read8(output logic [7:0] w);
        for (int i = 7; i >= 0; i--) begin
            w[i] = sdo_a;
            tick(1, 0, 0, 1'b0);
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] w;
        logic [7:0] keep;
        tick(0, 0, 0, 1);
        tick(0, 0, 0, 1);
        // R1: reset state
        chk("R1 design_in", {8'h0, din_a}, 16'h0);
        chk("R1 sdo", {15'h0, sdo_a}, 16'h0);

        // Table loop: R6/R4 latch order, R3 capture order
        foreach (VEC[k]) begin
            shift8(VEC[k][15:8]);
            // R2: first shifted bit now at sdo
            chk("R2 sdo after 8 shifts", {15'h0, sdo_a}, {15'h0, VEC[k][15]});
            tick(1, 0, 1, 1'b0);
            chk("R6 R4 latched order", {8'h0, din_a}, {8'h0, VEC[k][15:8]});
            tick(1, 1, 0, 1'b0);
            read8(w);
            chk("R3 captured order", {8'h0, w}, {8'h0, VEC[k][7:0]});
        end

        // R5: shifting and capture leave design_in alone without latch_en
        keep = din_a;
        shift8(8'h0F);
        tick(1, 1, 0, 1'b0);
        shift8(8'hE1);
        chk("R5 hold through activity", {8'h0, din_a}, {8'h0, keep});

        // R7: clock forwarded in both phases
        @(negedge clk); #1;
        chk("R7 low phase", {14'h0, fwd_a, fwd_b}, {14'h0, clk, clk});
        @(posedge clk); #1;
        chk("R7 high phase", {14'h0, fwd_a, fwd_b}, {14'h0, clk, clk});

        // R8: cascade of two links, first 8 bits reach the far link
        shift8(8'hC7);
        shift8(8'h2B);
        tick(1, 0, 1, 1'b0);
        chk("R8 cascade", {din_b, din_a}, 16'hC7_2B);
        // R3 across cascade: capture both then far end sees link B first
        tick(1, 1, 0, 1'b0);
        chk("R8 far sdo after capture", {15'h0, sdo_b}, {15'h0, ~din_b[7]});

        // R1: reset mid-operation clears latched inputs
        tick(0, 0, 0, 1'b1);
        chk("R1 mid reset design_in", {din_b, din_a}, 16'h0);
        chk("R1 mid reset sdo", {14'h0, sdo_b, sdo_a}, 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule